// File: doc/BRIEF.md
# Fault Escalation and Lockup Controller

This block decides, once per clock, which handler the processor enters when a synchronous fault is raised. Three fault classes arrive on their own request lines: memory-protection, bus and usage. A vector-table read failure during exception entry arrives on a separate line. The processor also reports which handler it is running now. Each class has a software-written enable bit. A class whose enable is set enters its own handler. A class whose enable is clear is sent to the catch-all hard fault handler instead.

A fault raised while a configurable fault handler is running escalates to hard fault. A fault raised while the hard fault handler or the non-maskable interrupt handler is running cannot preempt it, because hard fault sits at fixed priority -1 and the non-maskable interrupt at -2. In that case the block enters lockup. Lockup holds a reset request asserted and ignores every later fault. Only the external reset clears it.

Sticky status flags record the class that won, whether a configurable fault was pushed up to hard fault, and whether a vector read failed. Software clears each flag by writing 1 to it.

Top module: `fault_escalation_top`

## Requirements
- R1: After reset the enables are all 0, `faultStatus` is 0, `handlerSel` is 0, `handlerEntry` is 0, and `lockup` and `resetHold` are 0.
- R2: When the execution context is thread (`execCtx`=0) and the winning class has its enable set, the cycle after the request `handlerSel` has exactly that class's bit set. The bit map is 0 memory-protection, 1 bus, 2 usage. The class status bit is set at the same position.
- R3: When the winning class has its enable clear, the cycle after the request `handlerSel` is bit 3 (hard fault). `faultStatus` bit 3 (forced) and the class status bit are set.
- R4: When several class requests arrive in the same cycle, only the lowest-numbered one is handled. The order is memory-protection, then bus, then usage.
- R5: A class request while a configurable fault handler runs (`execCtx`=1) selects hard fault and sets status bit 3, whatever the enables are.
- R6: `vecFetchErr` with `execCtx` 0 or 1 selects hard fault and sets status bit 4. It takes precedence over class requests in the same cycle, and no class status bit is set then.
- R7: Any request while the hard fault handler (`execCtx`=2) or the non-maskable handler (`execCtx`=3) runs gives no handler entry. The cycle after the request `lockup` and `resetHold` are 1. They stay 1 and all later requests are ignored until `rstN` is asserted.
- R8: Status bits are sticky. `statClrEn` with `statClrMask` clears the bits set in the mask. A bit being set in the same cycle stays set.
- R9: `cfgWrEn` loads `cfgWrData` into the enables (bit i enables class i). The new enables route requests from the following cycle on.
- R10: `handlerEntry` is 1 for exactly one cycle per accepted fault, and only then. `handlerSel` is one-hot while `handlerEntry` is 1 and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous external reset |
| faultReq | input | 3 | Class fault requests (0 mem-protect, 1 bus, 2 usage) |
| vecFetchErr | input | 1 | Vector-table read failed during exception entry |
| execCtx | input | 2 | Running context: 0 thread, 1 configurable fault handler, 2 hard fault handler, 3 non-maskable handler |
| cfgWrEn | input | 1 | Write strobe for the class enables |
| cfgWrData | input | 3 | New class enable values |
| statClrEn | input | 1 | Write-1-to-clear strobe for the status |
| statClrMask | input | 5 | Status bits to clear |
| handlerSel | output | 4 | One-hot handler select (bits 0..2 classes, bit 3 hard fault) |
| handlerEntry | output | 1 | One-cycle handler entry strobe |
| faultStatus | output | 5 | Sticky status: bits 0..2 class, 3 forced to hard, 4 vector failure |
| lockup | output | 1 | Lockup state |
| resetHold | output | 1 | Reset request held while locked up |

## Verification
The directed cases target several likely faults. All three classes raised together with mixed enables: a design with reversed priority, or one that checked the wrong class's enable, would enter the wrong handler. A vector failure that coincides with a class request: getting this wrong would either set a class flag or skip the vector flag. Requests during the hard fault and non-maskable contexts: a design that treated these like other nested faults would strobe an entry instead of locking up. A design with the wrong lockup hold would drop `resetHold` on a later request. Status clears that coincide with a new setting would expose a clear that wins over the set. A random stream with all contexts, enables and clears mixed in is compared each cycle against a bench model.

// File: rtl/fault_esc_pkg.sv
package fault_esc_pkg;

  localparam int IDXW = 4;  // supports up to 16 classes

  typedef enum logic [1:0] {
    CTX_THREAD = 2'd0,
    CTX_CFG    = 2'd1,
    CTX_HARD   = 2'd2,
    CTX_NMI    = 2'd3
  } execCtx_t;

  typedef struct packed {
    logic            enter;    // accepted fault, handler entry
    logic            toHard;   // route to catch-all handler
    logic            lock;     // go to lockup
    logic [IDXW-1:0] cls;      // winning class index
    logic            clsHit;   // a class won arbitration
    logic            forced;   // class pushed up to hard fault
    logic            vecFail;  // vector fetch failure
  } ctrlStrobe_t;

endpackage

// File: rtl/fault_esc_ctrl.sv
module fault_esc_ctrl
  import fault_esc_pkg::*;
#(
  parameter int NumCls = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NumCls-1:0] faultReq,
  input  logic              vecFetchErr,
  input  logic [1:0]        execCtx,
  input  logic [NumCls-1:0] classEn,
  output ctrlStrobe_t       strobe,
  output logic              locked
);

  logic [IDXW-1:0] winIdx;
  logic            winFound;
  logic            winEn;
  execCtx_t        ctx;

  assign ctx = execCtx_t'(execCtx);

  // lowest index wins: scan from the top down
  always_comb begin
    winIdx   = '0;
    winFound = 1'b0;
    winEn    = 1'b0;
    for (int i = NumCls - 1; i >= 0; i--) begin
      if (faultReq[i]) begin
        winIdx   = IDXW'(i);
        winFound = 1'b1;
        winEn    = classEn[i];
      end
    end
  end

  always_comb begin
    strobe = '0;
    if (!locked && (winFound || vecFetchErr)) begin
      if (ctx == CTX_HARD || ctx == CTX_NMI) begin
        strobe.lock = 1'b1;
      end else begin
        strobe.enter = 1'b1;
        if (vecFetchErr) begin
          strobe.toHard  = 1'b1;
          strobe.vecFail = 1'b1;
        end else begin
          strobe.cls    = winIdx;
          strobe.clsHit = 1'b1;
          if (ctx == CTX_CFG || !winEn) begin
            strobe.toHard = 1'b1;
            strobe.forced = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            locked <= 1'b0;
    else if (strobe.lock) locked <= 1'b1;
  end

endmodule

// File: rtl/fault_esc_dp.sv
module fault_esc_dp
  import fault_esc_pkg::*;
#(
  parameter int NumCls = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              cfgWrEn,
  input  logic [NumCls-1:0] cfgWrData,
  input  logic              statClrEn,
  input  logic [NumCls+1:0] statClrMask,
  output logic [NumCls-1:0] classEn,
  output logic [NumCls:0]   handlerSel,
  output logic              handlerEntry,
  output logic [NumCls+1:0] faultStatus
);

  localparam int SelW  = NumCls + 1;
  localparam int StatW = NumCls + 2;

  logic [SelW-1:0]  selNext;
  logic [StatW-1:0] statSet;
  logic [StatW-1:0] statClr;

  for (genvar g = 0; g < NumCls; g++) begin : g_cls
    assign selNext[g] = strobe.enter && !strobe.toHard && (strobe.cls == IDXW'(g));
    assign statSet[g] = strobe.clsHit && (strobe.cls == IDXW'(g));
  end
  assign selNext[NumCls]   = strobe.enter && strobe.toHard;
  assign statSet[NumCls]   = strobe.forced;
  assign statSet[NumCls+1] = strobe.vecFail;
  assign statClr           = statClrEn ? statClrMask : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      classEn      <= '0;
      handlerSel   <= '0;
      handlerEntry <= 1'b0;
      faultStatus  <= '0;
    end else begin
      if (cfgWrEn) classEn <= cfgWrData;
      handlerSel   <= selNext;
      handlerEntry <= strobe.enter;
      faultStatus  <= (faultStatus & ~statClr) | statSet;
    end
  end

endmodule

// File: rtl/fault_escalation_top.sv
module fault_escalation_top
  import fault_esc_pkg::*;
#(
  parameter int NumCls = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NumCls-1:0] faultReq,
  input  logic              vecFetchErr,
  input  logic [1:0]        execCtx,
  input  logic              cfgWrEn,
  input  logic [NumCls-1:0] cfgWrData,
  input  logic              statClrEn,
  input  logic [NumCls+1:0] statClrMask,
  output logic [NumCls:0]   handlerSel,
  output logic              handlerEntry,
  output logic [NumCls+1:0] faultStatus,
  output logic              lockup,
  output logic              resetHold
);

  ctrlStrobe_t       strobe;
  logic [NumCls-1:0] faultEn;
  logic              locked;

  fault_esc_ctrl #(.NumCls(NumCls)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .faultReq   (faultReq),
    .vecFetchErr(vecFetchErr),
    .execCtx    (execCtx),
    .classEn    (faultEn),
    .strobe     (strobe),
    .locked     (locked)
  );

  fault_esc_dp #(.NumCls(NumCls)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cfgWrEn     (cfgWrEn),
    .cfgWrData   (cfgWrData),
    .statClrEn   (statClrEn),
    .statClrMask (statClrMask),
    .classEn     (faultEn),
    .handlerSel  (handlerSel),
    .handlerEntry(handlerEntry),
    .faultStatus (faultStatus)
  );

  assign lockup    = locked;
  assign resetHold = locked;

endmodule

// File: rtl/fault_esc_chk.sv
module fault_esc_chk #(
  parameter int NumCls = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [NumCls-1:0] faultReq,
  input logic              vecFetchErr,
  input logic [1:0]        execCtx,
  input logic              statClrEn,
  input logic [NumCls+1:0] statClrMask,
  input logic [NumCls:0]   handlerSel,
  input logic              handlerEntry,
  input logic [NumCls+1:0] faultStatus,
  input logic              lockup,
  input logic [NumCls-1:0] faultEn
);

  logic anyReq;
  assign anyReq = (|faultReq) || vecFetchErr;

  p_sel_onehot_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(handlerSel));

  p_entry_sel_r10: assert property (@(posedge clk) disable iff (!rstN)
    handlerEntry == (handlerSel != '0));

  p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    lockup |=> lockup);

  p_lock_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    lockup |-> !handlerEntry);

  p_hard_ctx_lock_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!lockup && anyReq && execCtx[1]) |=> lockup);

  p_vec_hard_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!lockup && vecFetchErr && !execCtx[1]) |=> (handlerSel[NumCls] && faultStatus[NumCls+1]));

  p_nested_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!lockup && (|faultReq) && !vecFetchErr && execCtx == 2'd1)
      |=> (handlerSel[NumCls] && faultStatus[NumCls]));

  p_disabled_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!lockup && faultReq[0] && !vecFetchErr && execCtx == 2'd0 && !faultEn[0])
      |=> handlerSel[NumCls]);

  p_enabled_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!lockup && faultReq[0] && !vecFetchErr && execCtx == 2'd0 && faultEn[0])
      |=> handlerSel[0]);

  p_status_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (faultStatus[0] && !(statClrEn && statClrMask[0])) |=> faultStatus[0]);

endmodule

bind fault_escalation_top fault_esc_chk #(.NumCls(NumCls)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .faultReq   (faultReq),
  .vecFetchErr(vecFetchErr),
  .execCtx    (execCtx),
  .statClrEn  (statClrEn),
  .statClrMask(statClrMask),
  .handlerSel (handlerSel),
  .handlerEntry(handlerEntry),
  .faultStatus(faultStatus),
  .lockup     (lockup),
  .faultEn    (faultEn)
);

// File: tb/fault_escalation_top_tb.sv
module fault_escalation_top_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] faultReq = '0;
  logic       vecFetchErr = 1'b0;
  logic [1:0] execCtx = '0;
  logic       cfgWrEn = 1'b0;
  logic [2:0] cfgWrData = '0;
  logic       statClrEn = 1'b0;
  logic [4:0] statClrMask = '0;
  logic [3:0] handlerSel;
  logic       handlerEntry;
  logic [4:0] faultStatus;
  logic       lockup;
  logic       resetHold;

  int nChecks = 0;
  int nFails  = 0;

  // bench model state
  logic [2:0] mEn = '0;
  logic [4:0] mSt = '0;
  logic       mLock = 1'b0;
  logic [3:0] mSel = '0;
  logic       mEntry = 1'b0;

  fault_escalation_top u_dut (
    .clk(clk), .rstN(rstN), .faultReq(faultReq), .vecFetchErr(vecFetchErr),
    .execCtx(execCtx), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .statClrEn(statClrEn), .statClrMask(statClrMask), .handlerSel(handlerSel),
    .handlerEntry(handlerEntry), .faultStatus(faultStatus), .lockup(lockup),
    .resetHold(resetHold)
  );

  always #4 clk = ~clk;

  function automatic int lowestSet(input logic [2:0] v);
    for (int i = 0; i < 3; i++) if (v[i]) return i;
    return -1;
  endfunction

  // next model state from the requirements
  task automatic modelStep(input logic [2:0] req, input logic vec, input logic [1:0] ctx,
                           input logic wr, input logic [2:0] wd, input logic clr,
                           input logic [4:0] cm, input logic doRst);
    logic [4:0] setV;
    int w;
    if (doRst) begin
      mEn = '0; mSt = '0; mLock = 1'b0; mSel = '0; mEntry = 1'b0;
      return;
    end
    setV = '0; mSel = '0; mEntry = 1'b0;
    if (!mLock && (req != 0 || vec)) begin
      if (ctx >= 2) begin
        mLock = 1'b1;                                   // R7
      end else if (vec) begin
        mSel = 4'b1000; setV = 5'b10000;                // R6
      end else begin
        w = lowestSet(req);                             // R4
        if (ctx == 2'd1 || !mEn[w]) begin
          mSel = 4'b1000; setV = 5'b01000 | (5'd1 << w); // R3 / R5
        end else begin
          mSel = 4'(1 << w); setV = 5'd1 << w;          // R2
        end
      end
      mEntry = (mSel != 0);
    end
    if (wr) mEn = wd;                                   // R9
    mSt = (mSt & ~(clr ? cm : 5'd0)) | setV;            // R8
  endtask

  task automatic step(input logic [2:0] req, input logic vec, input logic [1:0] ctx,
                      input logic wr, input logic [2:0] wd, input logic clr,
                      input logic [4:0] cm, input logic doRst, input string tag);
    logic [11:0] act, exp;
    faultReq = req; vecFetchErr = vec; execCtx = ctx;
    cfgWrEn = wr; cfgWrData = wd; statClrEn = clr; statClrMask = cm;
    rstN = !doRst;
    modelStep(req, vec, ctx, wr, wd, clr, cm, doRst);
    @(negedge clk);
    act = {handlerSel, handlerEntry, faultStatus, lockup, resetHold};
    exp = {mSel, mEntry, mSt, mLock, mLock};
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: sel/entry/status/lockup/hold actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic idle(input string tag);
    step(3'b000, 1'b0, 2'd0, 1'b0, 3'b000, 1'b0, 5'b0, 1'b0, tag);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    step(3'b000, 0, 2'd0, 0, 3'b000, 0, 5'b0, 1, "R1 reset state");
    idle("R1 reset state held");
    step(3'b001, 0, 2'd0, 0, 3'b000, 0, 5'b0, 0, "R3 class disabled after reset");
    step(3'b000, 0, 2'd0, 1, 3'b111, 1, 5'b11111, 0, "R9 enable write / R8 clear");
    step(3'b001, 0, 2'd0, 0, 3'b000, 0, 5'b0, 0, "R2 mem-protect enabled");
    idle("R10 strobe single cycle");
    step(3'b010, 0, 2'd0, 0, 3'b000, 0, 5'b0, 0, "R2 bus enabled");
    step(3'b100, 0, 2'd0, 0, 3'b000, 0, 5'b0, 0, "R2 usage enabled");
    step(3'b111, 0, 2'd0, 1, 3'b101, 1, 5'b11111, 0, "R4 all three, mem-protect wins");
    step(3'b110, 0, 2'd0, 0, 3'b000, 0, 5'b0, 0, "R4 bus over usage, bus disabled R3");
    step(3'b100, 0, 2'd0, 0, 3'b000, 0, 5'b0, 0, "R2 usage still enabled");
    step(3'b001, 0, 2'd1, 0, 3'b000, 1, 5'b11111, 0, "R5 nested fault escalates");
    step(3'b011, 1, 2'd0, 1, 3'b111, 1, 5'b11111, 0, "R6 vector failure wins");
    step(3'b000, 1, 2'd1, 0, 3'b000, 0, 5'b0, 0, "R6 vector failure in handler");
    step(3'b010, 0, 2'd0, 1, 3'b000, 1, 5'b00010, 0, "R8 set beats clear same cycle");
    step(3'b000, 0, 2'd0, 1, 3'b000, 1, 5'b01000, 0, "R8 clear one bit only");
    step(3'b100, 0, 2'd2, 0, 3'b000, 0, 5'b0, 0, "R7 fault in hard handler locks");
    step(3'b001, 0, 2'd0, 1, 3'b111, 0, 5'b0, 0, "R7 requests ignored while locked");
    step(3'b000, 1, 2'd1, 0, 3'b000, 0, 5'b0, 0, "R7 lockup holds");
    step(3'b000, 0, 2'd0, 0, 3'b000, 0, 5'b0, 1, "R7 external reset leaves lockup");
    idle("R1 clean after lockup reset");
    step(3'b000, 1, 2'd3, 0, 3'b000, 0, 5'b0, 0, "R7 fault in non-maskable handler");
    step(3'b000, 0, 2'd0, 0, 3'b000, 0, 5'b0, 1, "R1 reset again");

    void'($urandom(32'd20240611));
    for (int k = 0; k < 4000; k++) begin
      logic [2:0] req; logic vec; logic [1:0] ctx; int c;
      c   = $urandom % 16;
      ctx = (c < 10) ? 2'd0 : (c < 14) ? 2'd1 : (c == 14) ? 2'd2 : 2'd3;
      req = ($urandom % 2 == 0) ? 3'b000 : 3'($urandom % 8);
      vec = ($urandom % 10 == 0);
      step(req, vec, ctx, ($urandom % 8 == 0), 3'($urandom % 8), ($urandom % 4 == 0),
           5'($urandom % 32), (mLock && ($urandom % 4 == 0)), "R2/R3/R4/R5/R6/R7/R8/R9/R10 random");
    end

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule